// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a clocked monostable pulse generator. A programmable down-counter sets the pulse length, so no analog timing parts are needed. Two trigger inputs are provided. One is active low and fires on its falling edge. The other is active high and fires on its rising edge. Each trigger is qualified by the level of the other, so one input can act as an enable for the other.

When a trigger is accepted, the block loads the width value, given in clock cycles, and drives the true output high. It drives the complementary output low at the same moment. An active-low clear has priority over everything else. It ends any pulse and blocks new pulses for as long as it is held low.

A mode input selects how triggers that arrive during a pulse are handled. In retriggerable mode they restart the timing, which extends the pulse. In non-retriggerable mode they are ignored. The trigger inputs and the clear are asynchronous to the clock and pass through synchronizer chains before any decision is made. All pins are plain control pins. There is no data stream, so there is no valid/ready handshake.

Top module: `oneshot_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released with no trigger, `pulse` is 0 and `pulse_n` is 1.
- R2: A 1-to-0 change on `trig_fall_n` starts a pulse only if `trig_rise` is 1. If `trig_rise` is 0, the change produces no pulse.
- R3: A 0-to-1 change on `trig_rise` starts a pulse only if `trig_fall_n` is 0. If `trig_fall_n` is 1, the change produces no pulse.
- R4: Each trigger input and the clear pass through a 2-flop synchronizer. A level must be held for at least one clock period to be seen. `pulse` goes to 1 at the third rising clock edge after the input change, counting the first edge that samples it. `pulse` then stays at 1 for exactly `width` clock cycles, where `width` is the value present when the trigger is accepted.
- R5: A trigger accepted while `width` is 0 produces no pulse.
- R6: With `retrig_en` = 1, a trigger that arrives during a pulse reloads the counter with `width`. `pulse` stays at 1 without a gap. If the second trigger comes k cycles after the first, the total high time is k + `width` cycles.
- R7: With `retrig_en` = 0, a trigger that arrives while `pulse` is 1 is ignored, and the pulse keeps its original length.
- R8: Driving `clr_n` to 0 forces `pulse` to 0 at the third rising clock edge after the change, and keeps it at 0 while `clr_n` stays low.
- R9: While `clr_n` is 0, trigger edges are ignored, and both outputs hold steady with no spike.
- R10: A 0-to-1 change on `clr_n` with no trigger edge does not start a pulse.
- R11: If `clr_n` rises at the same time as a valid trigger edge, the trigger is honoured and a full pulse of `width` cycles is produced.
- R12: `pulse_n` is always the exact inverse of `pulse`. Both are driven directly by registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_fall_n | input | 1 | Trigger that fires on its falling edge (asynchronous) |
| trig_rise | input | 1 | Trigger that fires on its rising edge (asynchronous) |
| clr_n | input | 1 | Active-low clear (asynchronous), overrides everything |
| retrig_en | input | 1 | 1 = a trigger during a pulse restarts the timing, 0 = it is ignored |
| width | input | WIDTH_W | Pulse length in clock cycles, sampled when a trigger is accepted |
| pulse | output | 1 | True pulse output |
| pulse_n | output | 1 | Complementary pulse output |

## Verification
The bench builds the block with its defaults: WIDTH_W = 8 and SYNC_STAGES = 2. The 8-bit width lets the bench test the longest pulse, 255 cycles, as well as the one-cycle and zero-width cases. The two-stage synchronizer fixes the trigger-to-output latency at three edges, so the bench can check the exact start cycle of each pulse. It can also place a retrigger, a clear and a clear release on chosen cycles relative to a running pulse.

// File: rtl/os_pkg.sv
package os_pkg;
  // Synchronized input bundle, in bit order {clear_n, rise, fall_n}
  localparam int NUM_SYNC = 3;
  localparam int IDX_FALL = 0;
  localparam int IDX_RISE = 1;
  localparam int IDX_CLR  = 2;
  // Idle levels: falling trigger high, rising trigger low, clear released
  localparam logic [NUM_SYNC-1:0] SYNC_IDLE = 3'b101;

  typedef struct packed {
    logic fall_hit;
    logic rise_hit;
  } trig_evt_t;
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/os_edge.sv
module os_edge
  import os_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fall_lvl,
  input  logic      rise_lvl,
  output trig_evt_t evt
);
  logic fall_prev, rise_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_prev <= 1'b1;
      rise_prev <= 1'b0;
    end else begin
      fall_prev <= fall_lvl;
      rise_prev <= rise_lvl;
    end
  end

  // each edge is qualified by the level of the other trigger input
  always_comb begin
    evt.fall_hit = fall_prev & ~fall_lvl & rise_lvl;
    evt.rise_hit = ~rise_prev & rise_lvl & ~fall_lvl;
  end

  p_fall_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fall_hit |=> !fall_prev);
  p_rise_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rise_hit |=> rise_prev);
endmodule

// File: rtl/os_timer.sv
module os_timer #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_act,
  input  logic               trig,
  input  logic               retrig_en,
  input  logic [WIDTH_W-1:0] width,
  output logic               pulse_q,
  output logic               pulse_n_q
);
  logic [WIDTH_W-1:0] cnt_q, cnt_d;
  logic               pulse_d;
  logic               start;

  assign start = trig & ~clr_act & (width != '0) & (retrig_en | ~pulse_q);

  // clear first, then load, then count down
  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = pulse_q;
    if (clr_act) begin
      cnt_d   = '0;
      pulse_d = 1'b0;
    end else if (start) begin
      cnt_d   = width;
      pulse_d = 1'b1;
    end else if (pulse_q) begin
      if (cnt_q <= WIDTH_W'(1)) begin
        cnt_d   = '0;
        pulse_d = 1'b0;
      end else begin
        cnt_d = cnt_q - WIDTH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pulse_q   <= 1'b0;
      pulse_n_q <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      pulse_q   <= pulse_d;
      pulse_n_q <= ~pulse_d;
    end
  end

  p_clear_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> !pulse_q);
  p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && !pulse_q) |=> $stable(pulse_q) && $stable(pulse_n_q));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pulse_q && (cnt_q == $past(width)));
  p_nonretrig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !retrig_en && !clr_act && cnt_q > WIDTH_W'(1))
      |=> pulse_q && (cnt_q == $past(cnt_q) - WIDTH_W'(1)));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_q && !start) |=> !pulse_q);
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_q && width == '0) |=> !pulse_q);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import os_pkg::*;
#(
  parameter int WIDTH_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_fall_n,
  input  logic               trig_rise,
  input  logic               clr_n,
  input  logic               retrig_en,
  input  logic [WIDTH_W-1:0] width,
  output logic               pulse,
  output logic               pulse_n
);
  logic [NUM_SYNC-1:0] raw_in, syn;
  trig_evt_t           evt;
  logic                trig;

  assign raw_in = {clr_n, trig_rise, trig_fall_n};

  os_sync #(.N(NUM_SYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  os_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .fall_lvl(syn[IDX_FALL]), .rise_lvl(syn[IDX_RISE]), .evt(evt)
  );

  assign trig = evt.fall_hit | evt.rise_hit;

  os_timer #(.WIDTH_W(WIDTH_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .clr_act(~syn[IDX_CLR]), .trig(trig), .retrig_en(retrig_en),
    .width(width), .pulse_q(pulse), .pulse_n_q(pulse_n)
  );

  // R12: outputs never agree
  p_complement_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pulse != pulse_n);
  // R11: a trigger seen with the clear already released is honoured
  p_release_trig_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && syn[IDX_CLR] && width != '0 && retrig_en) |=> pulse);
endmodule

// File: tb/oneshot_timer_tb.sv
`timescale 1ns/1ps
module oneshot_timer_tb;
  localparam int WW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_fall_n = 1'b1, trig_rise = 1'b0, clr_n = 1'b1, retrig_en = 1'b1;
  logic [WW-1:0] width = '0;
  logic pulse, pulse_n;

  int checks = 0, fails = 0;
  int cyc = 0;
  int hi_n = 0, npulses = 0, first_hi = -1, comp_err = 0;
  logic prev_p = 1'b0;

  always #4 clk = ~clk;

  oneshot_timer #(.WIDTH_W(WW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_fall_n(trig_fall_n), .trig_rise(trig_rise),
    .clr_n(clr_n), .retrig_en(retrig_en), .width(width),
    .pulse(pulse), .pulse_n(pulse_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pulse) hi_n <= hi_n + 1;
    if (pulse && !prev_p) begin
      npulses <= npulses + 1;
      if (first_hi < 0) first_hi <= cyc;
    end
    prev_p <= pulse;
    if (pulse_n !== ~pulse) comp_err <= comp_err + 1;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mon_clear();
    @(posedge clk);
    hi_n = 0; npulses = 0; first_hi = -1;
    @(negedge clk);
  endtask

  task automatic mon_settle();
    @(posedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire_fall(output int d);
    trig_rise = 1'b1; wait_n(3);
    d = cyc; trig_fall_n = 1'b0; wait_n(3);
    trig_fall_n = 1'b1; wait_n(3);
    trig_rise = 1'b0;
  endtask

  task automatic fire_rise(output int d);
    trig_fall_n = 1'b0; wait_n(3);
    d = cyc; trig_rise = 1'b1; wait_n(3);
    trig_rise = 1'b0; wait_n(3);
    trig_fall_n = 1'b1;
  endtask

  localparam int TV_N = 6;
  localparam int TV_RISE [TV_N] = '{0, 1, 0, 1, 1, 0};
  localparam int TV_W    [TV_N] = '{1, 3, 7, 0, 255, 2};
  localparam int TV_EXP  [TV_N] = '{1, 3, 7, 0, 255, 2};

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int d;
    wait_n(3);
    check("R1 pulse in reset", int'(pulse), 0);
    check("R1 pulse_n in reset", int'(pulse_n), 1);
    rst_n = 1'b1;
    mon_clear();
    wait_n(6); mon_settle();
    check("R1 idle after reset", npulses, 0);
    check("R1 pulse_n idle", int'(pulse_n), 1);

    // table: R2/R3 accepted triggers, R4 length and latency, R5 zero width
    for (int i = 0; i < TV_N; i++) begin
      width = 8'(TV_W[i]); retrig_en = 1'b1;
      mon_clear();
      if (TV_RISE[i] != 0) fire_rise(d); else fire_fall(d);
      wait_n(TV_W[i] + 10); mon_settle();
      check(TV_RISE[i] != 0 ? "R3 R4 length" : "R2 R4 length", hi_n, TV_EXP[i]);
      check(TV_EXP[i] == 0 ? "R5 zero width count" : "R4 pulse count",
            npulses, TV_EXP[i] != 0 ? 1 : 0);
      if (TV_EXP[i] != 0) check("R4 start cycle", first_hi, d + 3);
    end

    // R2/R3: unqualified edges ignored
    width = 8'd5;
    mon_clear();
    trig_fall_n = 1'b0; wait_n(4);
    trig_fall_n = 1'b1; wait_n(4);
    trig_rise = 1'b1; wait_n(4);
    trig_rise = 1'b0; wait_n(10); mon_settle();
    check("R2 R3 unqualified edges", npulses, 0);

    // R6 retrigger extends
    width = 8'd6; retrig_en = 1'b1;
    mon_clear();
    trig_fall_n = 1'b0; wait_n(3);
    trig_rise = 1'b1; wait_n(2); trig_rise = 1'b0; wait_n(2);
    trig_rise = 1'b1; wait_n(2); trig_rise = 1'b0;
    wait_n(20); mon_settle();
    check("R6 retrigger length", hi_n, 10);
    check("R6 single pulse", npulses, 1);

    // R7 non-retriggerable
    retrig_en = 1'b0;
    mon_clear();
    trig_rise = 1'b1; wait_n(2); trig_rise = 1'b0; wait_n(2);
    trig_rise = 1'b1; wait_n(2); trig_rise = 1'b0;
    wait_n(20); mon_settle();
    check("R7 ignored retrigger length", hi_n, 6);
    check("R7 single pulse", npulses, 1);
    retrig_en = 1'b1;

    // R8 clear cuts pulse, R9 triggers blocked, R10 release alone
    width = 8'd20;
    mon_clear();
    trig_rise = 1'b1; wait_n(5);
    clr_n = 1'b0; wait_n(8); mon_settle();
    check("R8 clear cut length", hi_n, 5);
    check("R8 output low under clear", int'(pulse), 0);
    trig_rise = 1'b0; wait_n(3); trig_rise = 1'b1; wait_n(3);
    trig_rise = 1'b0; wait_n(3); trig_rise = 1'b1; wait_n(3);
    trig_rise = 1'b0; wait_n(8); mon_settle();
    check("R9 no pulse while cleared", npulses, 1);
    check("R9 length unchanged", hi_n, 5);
    clr_n = 1'b1; wait_n(12); mon_settle();
    check("R10 release makes no pulse", npulses, 1);

    // R11 release together with trigger
    clr_n = 1'b0; wait_n(5);
    mon_clear();
    d = cyc; clr_n = 1'b1; trig_rise = 1'b1;
    wait_n(30); mon_settle();
    check("R11 release with trigger length", hi_n, 20);
    check("R11 start cycle", first_hi, d + 3);
    trig_rise = 1'b0; wait_n(3); trig_fall_n = 1'b1; wait_n(3);

    mon_settle();
    check("R12 complement mismatches", comp_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule